// File: doc/BRIEF.md
# Flash Region Access Gate

This block sits between a request source and a flash cycle sequencer. Each request carries three things: a region code, a cycle type and a byte offset. For read, write and erase cycles, the gate relocates the offset into the flash linear address space using the base of the selected region. It also tests the offset against that region's upper bound and against a permission word. It returns the linear address together with one two-bit verdict.

Cycles that do not address the array are the parameter-table read, the identification read and the two status-register cycles. They bypass translation and checking, and their offset is handed on unchanged. A whole-device region code also skips every check: its offset is already a linear address.

A small write-only configuration port loads the five region windows and the permission word. Each response appears exactly one clock after its request strobe.

Top module: `flash_region_gate`

## Requirements
- R1: While `rst` is high and after its release, before any request, `rsp_valid`, `rsp_status` and `rsp_addr` are all zero.
- R2: A response with `rsp_valid` high appears exactly one clock after each cycle in which `req_valid` is high. `rsp_valid` is low in every other cycle.
- R3: Region codes are 0 descriptor, 1 boot firmware, 2 management engine, 3 network controller and 4 platform data. For a read (cycle 0), write (1) or erase (2) on one of these regions, `rsp_addr` is the offset plus the region base times 4096, modulo 2^27.
- R4: Each region has a limit field. When the limit is nonzero and the unrelocated offset exceeds limit*4096+4095, the verdict is invalid (code 10). A zero limit disables this test.
- R5: Permission bit r is the read grant of region r, and bit 5+r is its write grant. Regions 2, 3 and 4 test the write grant for writes and erases and the read grant for reads. Regions 0 and 1 test their read grant for every cycle type. A clear tested bit gives denied (code 11); otherwise the verdict is ok (code 00).
- R6: Region code 7 (whole device) with cycle 0, 1 or 2 always gives ok, and `rsp_addr` equals the offset.
- R7: Region codes 5 and 6 with cycle 0, 1 or 2 give unsupported (code 01), and `rsp_addr` equals the offset.
- R8: Cycle codes 3 (parameter table read), 4 (identification read), 5 (status read) and 6 (status write) give ok with `rsp_addr` equal to the offset, for any region code and any configuration.
- R9: Cycle code 7 is unrecognised and gives invalid with `rsp_addr` equal to the offset.
- R10: When both tests fail, the limit test wins over the permission test: the verdict is invalid, not denied.
- R11: Configuration writes with `cfg_sel` 0 to 4 load region r. The base is `cfg_data[14:0]` and the limit is `cfg_data[29:15]`. `cfg_sel` 5 loads the permission word. A write takes effect for any request strobed in a later cycle. `cfg_sel` 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target: 0-4 region window, 5 permission word |
| cfg_data | input | 30 | Configuration value |
| req_valid | input | 1 | Request strobe |
| req_region | input | 3 | Region code |
| req_cycle | input | 3 | Cycle type code |
| req_addr | input | 27 | Region-relative byte offset |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_status | output | 2 | 00 ok, 01 unsupported, 10 invalid, 11 denied |
| rsp_addr | output | 27 | Linear address or passed-through offset |

## Verification
The hardest case to reach from the ports is the asymmetric choice between the two grants. It only shows when a region's read and write grants differ, and only for a write or erase. The stimulus therefore loads a permission word in which engine and network regions have opposite grants. It then rewrites that word mid-run and replays the same requests. The case where limit and permission fail together needs an offset just past a nonzero limit in a region that is also denied. A directed pair of requests sits on both sides of that bound, and a long random stream, checked against a model built from the requirements, covers the wrap of the 27-bit address.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_UNSUP  = 2'b01,
    ST_INVAL  = 2'b10,
    ST_DENIED = 2'b11
  } gate_status_e;

  typedef enum logic [2:0] {
    CY_READ   = 3'd0,
    CY_WRITE  = 3'd1,
    CY_ERASE  = 3'd2,
    CY_PTABLE = 3'd3,
    CY_IDENT  = 3'd4,
    CY_STRD   = 3'd5,
    CY_STWR   = 3'd6,
    CY_BAD    = 3'd7
  } cycle_e;

  localparam logic [2:0] REGION_WHOLE = 3'd7;

endpackage

// File: rtl/gate_window_store.sv
module gate_window_store #(
  parameter int NREG   = 5,
  parameter int BASE_W = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [2:0]                 cfg_sel,
  input  logic [2*BASE_W-1:0]        cfg_data,
  output logic [NREG-1:0][BASE_W-1:0] win_base,
  output logic [NREG-1:0][BASE_W-1:0] win_limit,
  output logic [2*BASE_W-1:0]        perm_word
);
  localparam int CFG_W    = 2 * BASE_W;
  localparam int PERM_SEL = NREG;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_win
      always_ff @(posedge clk) begin
        if (rst) begin
          win_base[g]  <= '0;
          win_limit[g] <= '0;
        end else if (cfg_we && cfg_sel == 3'(g)) begin
          win_base[g]  <= cfg_data[BASE_W-1:0];
          win_limit[g] <= cfg_data[CFG_W-1:BASE_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      perm_word <= '0;
    else if (cfg_we && cfg_sel == 3'(PERM_SEL))
      perm_word <= cfg_data;
  end

  AST_UNUSED_SEL_KEEPS_PERM: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel > 3'(PERM_SEL)) |=> $stable(perm_word)); // R11

endmodule

// File: rtl/gate_region_pick.sv
module gate_region_pick #(
  parameter int              NREG      = 5,
  parameter int              BASE_W    = 15,
  parameter logic [NREG-1:0] ASYM_MASK = 5'b11100
) (
  input  logic [2:0]                  region,
  input  logic [NREG-1:0][BASE_W-1:0] win_base,
  input  logic [NREG-1:0][BASE_W-1:0] win_limit,
  input  logic [2*BASE_W-1:0]         perm_word,
  output logic                        known,
  output logic                        split_grant,
  output logic [BASE_W-1:0]           sel_base,
  output logic [BASE_W-1:0]           sel_limit,
  output logic                        rd_grant,
  output logic                        wr_grant
);
  always_comb begin
    known       = 1'b0;
    split_grant = 1'b0;
    sel_base    = '0;
    sel_limit   = '0;
    rd_grant    = 1'b0;
    wr_grant    = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (region == 3'(i)) begin
        known       = 1'b1;
        split_grant = ASYM_MASK[i];
        sel_base    = win_base[i];
        sel_limit   = win_limit[i];
        rd_grant    = perm_word[i];
        wr_grant    = perm_word[NREG + i];
      end
    end
  end
endmodule

// File: rtl/gate_decide.sv
module gate_decide
  import flash_gate_pkg::*;
#(
  parameter int BASE_W = 15,
  parameter int UNIT_W = 12,
  parameter int ADDR_W = BASE_W + UNIT_W
) (
  input  logic [2:0]        region,
  input  logic [2:0]        cycle,
  input  logic [ADDR_W-1:0] offset,
  input  logic              known,
  input  logic              split_grant,
  input  logic [BASE_W-1:0] sel_base,
  input  logic [BASE_W-1:0] sel_limit,
  input  logic              rd_grant,
  input  logic              wr_grant,
  output gate_status_e      verdict,
  output logic [ADDR_W-1:0] lin_addr
);
  logic              array_cycle;
  logic              grant;
  logic [ADDR_W-1:0] bound;

  assign array_cycle = (cycle == CY_READ) || (cycle == CY_WRITE) || (cycle == CY_ERASE);
  assign grant       = (split_grant && cycle != CY_READ) ? wr_grant : rd_grant;
  assign bound       = {sel_limit, {UNIT_W{1'b1}}};

  always_comb begin
    verdict  = ST_OK;
    lin_addr = offset;
    if (cycle == CY_BAD) begin
      verdict = ST_INVAL;
    end else if (array_cycle && region != REGION_WHOLE) begin
      if (!known) begin
        verdict = ST_UNSUP;
      end else begin
        lin_addr = offset + {sel_base, {UNIT_W{1'b0}}};
        if (sel_limit != '0 && offset > bound)
          verdict = ST_INVAL;
        else if (!grant)
          verdict = ST_DENIED;
      end
    end
  end
endmodule

// File: rtl/flash_region_gate.sv
module flash_region_gate
  import flash_gate_pkg::*;
#(
  parameter int NREG   = 5,
  parameter int BASE_W = 15,
  parameter int UNIT_W = 12,
  parameter int ADDR_W = BASE_W + UNIT_W,
  parameter int CFG_W  = 2 * BASE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              req_valid,
  input  logic [2:0]        req_region,
  input  logic [2:0]        req_cycle,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [ADDR_W-1:0] rsp_addr
);
  logic [NREG-1:0][BASE_W-1:0] win_base;
  logic [NREG-1:0][BASE_W-1:0] win_limit;
  logic [CFG_W-1:0]            perm_word;
  logic                        known, split_grant, rd_grant, wr_grant;
  logic [BASE_W-1:0]           sel_base, sel_limit;
  gate_status_e                verdict;
  logic [ADDR_W-1:0]           lin_addr;

  gate_window_store #(.NREG(NREG), .BASE_W(BASE_W)) u_store (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .win_base(win_base), .win_limit(win_limit), .perm_word(perm_word)
  );

  gate_region_pick #(.NREG(NREG), .BASE_W(BASE_W)) u_pick (
    .region(req_region), .win_base(win_base), .win_limit(win_limit),
    .perm_word(perm_word), .known(known), .split_grant(split_grant),
    .sel_base(sel_base), .sel_limit(sel_limit), .rd_grant(rd_grant), .wr_grant(wr_grant)
  );

  gate_decide #(.BASE_W(BASE_W), .UNIT_W(UNIT_W), .ADDR_W(ADDR_W)) u_decide (
    .region(req_region), .cycle(req_cycle), .offset(req_addr), .known(known),
    .split_grant(split_grant), .sel_base(sel_base), .sel_limit(sel_limit),
    .rd_grant(rd_grant), .wr_grant(wr_grant), .verdict(verdict), .lin_addr(lin_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= 2'b00;
      rsp_addr   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= verdict;
        rsp_addr   <= lin_addr;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2
  AST_WHOLE_DEVICE_PASS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_region == REGION_WHOLE && req_cycle < 3'd3)
    |=> (rsp_status == 2'b00 && rsp_addr == $past(req_addr))); // R6
  AST_UNKNOWN_REGION: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cycle < 3'd3 && (req_region == 3'd5 || req_region == 3'd6))
    |=> (rsp_status == 2'b01 && rsp_addr == $past(req_addr))); // R7
  AST_AUX_CYCLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cycle >= 3'd3 && req_cycle <= 3'd6)
    |=> (rsp_status == 2'b00 && rsp_addr == $past(req_addr))); // R8
  AST_BAD_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cycle == 3'd7) |=> (rsp_status == 2'b10)); // R9

endmodule

// File: tb/flash_region_gate_tb_top.sv
module flash_region_gate_tb_top;
  localparam int AW = 27;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [29:0]   cfg_data = '0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_region = '0;
  logic [2:0]    req_cycle = '0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_status;
  logic [AW-1:0] rsp_addr;

  always #4 clk = ~clk;

  flash_region_gate dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_region(req_region), .req_cycle(req_cycle),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_addr(rsp_addr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [14:0] m_base [5];
  logic [14:0] m_lim  [5];
  logic [29:0] m_perm;

  typedef struct packed { logic [1:0] st; logic [AW-1:0] addr; logic [7:0] tag; } exp_t;
  exp_t sb[$];

  function automatic exp_t model(input logic [2:0] rg, input logic [2:0] cy,
                                 input logic [AW-1:0] off, input logic [7:0] tag);
    exp_t e;
    logic g;
    e.tag = tag; e.st = 2'b00; e.addr = off;
    if (cy == 3'd7) e.st = 2'b10;                               // R9
    else if (cy >= 3'd3) e.st = 2'b00;                          // R8
    else if (rg == 3'd7) e.st = 2'b00;                          // R6
    else if (rg > 3'd4) e.st = 2'b01;                           // R7
    else begin
      e.addr = off + {m_base[rg], 12'h000};                     // R3
      g = (rg >= 3'd2 && cy != 3'd0) ? m_perm[5 + rg] : m_perm[rg]; // R5
      if (m_lim[rg] != 0 && off > {m_lim[rg], 12'hFFF}) e.st = 2'b10; // R4 R10
      else if (!g) e.st = 2'b11;
    end
    return e;
  endfunction

  task automatic cfg_write(input logic [2:0] sel, input logic [29:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    if (sel < 3'd5) begin m_base[sel] = d[14:0]; m_lim[sel] = d[29:15]; end
    else if (sel == 3'd5) m_perm = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [2:0] rg, input logic [2:0] cy,
                      input logic [AW-1:0] off, input logic [7:0] tag);
    @(negedge clk);
    req_valid = 1'b1; req_region = rg; req_cycle = cy; req_addr = off;
    sb.push_back(model(rg, cy, off, tag));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R2: response with nothing pending, got status %b addr %h expected none",
                   rsp_status, rsp_addr);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (rsp_status !== e.st || rsp_addr !== e.addr) begin
            fails++;
            $display("FAIL %s: got status %b addr %h expected status %b addr %h",
                     e.tag == 0 ? "R3/R4/R5" : $sformatf("R%0d", e.tag),
                     rsp_status, rsp_addr, e.st, e.addr);
          end
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin m_base[i] = '0; m_lim[i] = '0; end
    m_perm = '0;
    repeat (3) @(negedge clk);
    checks++;  // R1
    if (rsp_valid !== 1'b0 || rsp_status !== 2'b00 || rsp_addr !== '0) begin
      fails++;
      $display("FAIL R1: in reset got v=%b st=%b a=%h expected 0 0 0", rsp_valid, rsp_status, rsp_addr);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R1
    if (rsp_valid !== 1'b0 || rsp_status !== 2'b00 || rsp_addr !== '0) begin
      fails++;
      $display("FAIL R1: after reset got v=%b st=%b a=%h expected 0 0 0", rsp_valid, rsp_status, rsp_addr);
    end

    // R11 window loads: {limit, base}
    cfg_write(3'd0, {15'h0003, 15'h0001});
    cfg_write(3'd1, {15'h01FF, 15'h0100});
    cfg_write(3'd2, {15'h0010, 15'h0200});
    cfg_write(3'd3, {15'h0000, 15'h0300});
    cfg_write(3'd4, {15'h0000, 15'h7FFF});
    // R5 grants: read 0..3, write 2 and 4
    cfg_write(3'd5, 30'h28F);

    send(3'd1, 3'd0, 27'h0001234, 8'd3);   // R3 relocation
    send(3'd4, 3'd0, 27'h0002010, 8'd3);   // R3 wrap, region 4 read denied -> R5
    send(3'd4, 3'd1, 27'h0002010, 8'd3);   // R3 wrap, write granted
    send(3'd0, 3'd0, 27'h0003FFF, 8'd4);   // R4 at bound -> ok
    send(3'd0, 3'd0, 27'h0004000, 8'd4);   // R4 just past bound
    send(3'd3, 3'd0, 27'h7FFFFFF, 8'd4);   // R4 zero limit disables
    send(3'd3, 3'd1, 27'h0000100, 8'd5);   // R5 network write denied
    send(3'd2, 3'd2, 27'h0000100, 8'd5);   // R5 engine erase granted
    send(3'd1, 3'd1, 27'h0000040, 8'd5);   // R5 firmware write uses read grant
    send(3'd7, 3'd2, 27'h5555555, 8'd6);   // R6
    send(3'd5, 3'd0, 27'h0000010, 8'd7);   // R7
    send(3'd6, 3'd1, 27'h0000020, 8'd7);   // R7
    send(3'd6, 3'd3, 27'h0000030, 8'd8);   // R8 with unknown region
    send(3'd2, 3'd5, 27'h7FFFFFF, 8'd8);   // R8 past limit still ok
    send(3'd0, 3'd7, 27'h0000044, 8'd9);   // R9
    send(3'd4, 3'd0, 27'h0011000, 8'd10);  // zero limit, denied only

    // R10: engine limit 0x10 with write grant cleared
    cfg_write(3'd5, 30'h00F);
    send(3'd2, 3'd1, 27'h0011000, 8'd10);  // both fail -> invalid
    send(3'd2, 3'd1, 27'h0010FFF, 8'd10);  // only grant fails -> denied
    // R11: ignored selects must not disturb permissions or windows
    cfg_write(3'd6, 30'h3FFFFFFF);
    cfg_write(3'd7, 30'h3FFFFFFF);
    send(3'd2, 3'd1, 27'h0000010, 8'd11);
    send(3'd0, 3'd0, 27'h0000010, 8'd11);
    // R11 rewrite visible to next request
    cfg_write(3'd5, 30'h3FF);
    send(3'd3, 3'd1, 27'h0000100, 8'd11);

    for (int k = 0; k < 300; k++) begin
      if (k % 60 == 0) cfg_write(3'd5, 30'($urandom) & 30'h3FF);
      send(3'($urandom), 3'($urandom), 27'($urandom), 8'd0);
    end
    // R2 back-to-back requests
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      req_valid = 1'b1; req_region = 3'd1; req_cycle = 3'd0; req_addr = 27'(k * 4096);
      sb.push_back(model(3'd1, 3'd0, 27'(k * 4096), 8'd2));
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d responses missing, expected 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R2: watchdog expired, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule